// File: doc/BRIEF.md
# Exception Entry and Vector Generator

This block takes a processor into its exception state. Each cycle it may receive one request on a valid strobe. A request can carry several sources at once: a soft reset, a non-maskable interrupt, an external interrupt and a synchronous exception. The synchronous exception names its kind, and for address-translation faults it also gives the lookup result and the access direction. The block picks one source by fixed priority. On the next clock edge it presents the new program counter, the update for the 5-bit cause code, the saved return address and the status-bit set requests, each with its own write enable. A surrounding control-register file applies these values.

The current status bits come in as inputs: exception level, boot vectors and the special interrupt vector. The exception-base register, the current context register and the current address-space identifier are inputs as well. The outputs are registered. They hold their value between accepted requests, and the one-cycle strobes mark which values are fresh. On translation faults the block also produces the captured faulting address and the merged context and entry-high values. It tracks no state of its own beyond these output registers.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst_ni` is low, every output is zero, including all strobes, `taken_o` and all data outputs.
- R2: When more than one source is set on an accepted request, the grant order is soft reset, then NMI, then interrupt, then synchronous exception. Only the winner's effects appear.
- R3: For general exceptions (interrupt and synchronous), the vector base is 0xBFC00200 when `bev_i` is 1. Otherwise it is `ebase_i` with bits [9:0] cleared. `new_pc_o` is the base plus the offset.
- R4: The offset is 0x180 by default and 0x200 for an interrupt with `iv_i` set. It is 0x000 for a translation no-match (refill) fault taken with `exl_i` clear. A refill fault taken with `exl_i` set uses 0x180.
- R5: `exc_code_o` is written with `cause_we_o` on every general exception. The interrupt code is 0. The `sync_kind_i` encodings and their codes are: 1 instruction bus error 6, 2 data bus error 7, 3 syscall 8, 4 break 9, 5 reserved instruction 10, 6 coprocessor unusable 11, 7 overflow 12, 8 trap 13, 9 floating point 15. Code 0 means translation fault, as in R8.
- R6: When `exl_i` is clear, a general exception asserts `epc_we_o` and `exl_set_o`. In a delay slot (`in_delay_i`=1), `epc_o` is `pc_i`−4 and `bd_o`=1. Otherwise `epc_o` is `pc_i` and `bd_o`=0. With `exl_i` set, `epc_we_o` and `exl_set_o` stay low, and `epc_o` and `bd_o` keep their previous values.
- R7: A granted soft reset or NMI asserts `errepc_we_o`. `errepc_o` follows the same delay-slot rule as R6. The block asserts `erl_set_o` and `bev_set_o`, and sets `new_pc_o` to 0xBFC00000. A soft reset also asserts `sr_set_o`, and an NMI asserts `nmi_set_o`. The cause code and EPC are not written.
- R8: A translation fault (kind 0) takes its code from `xlat_res_i` and `is_store_i`. Result 0 (bad address) gives 4 for a load and 5 for a store. Result 1 (no match) gives 2 or 3 and counts as a refill. Result 2 (invalid) gives 2 or 3 without refill. Result 3 (dirty) gives 1.
- R9: A translation fault asserts `xlat_we_o` and sets `badvaddr_o` to `fault_addr_i`. `context_o` is `context_i` with bits [22:0] replaced by (`fault_addr_i`>>9) masked to bits [22:4]. `entryhi_o` takes `fault_addr_i`[31:13], zeros in [12:8] and `asid_i` in [7:0].
- R10: A coprocessor-unusable exception asserts `ce_we_o` with `ce_o` equal to `cop_num_i`.
- R11: A cycle with `req_valid_i` low, or with only a synchronous request whose `sync_kind_i` is 10 to 15, is ignored. All strobes stay low and all data outputs keep their values.
- R12: An accepted request shows its effects exactly one clock edge later. `taken_o` is high for that single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe qualifying all source flags |
| req_srst_i | input | 1 | Soft reset source |
| req_nmi_i | input | 1 | Non-maskable interrupt source |
| req_irq_i | input | 1 | External interrupt source |
| req_sync_i | input | 1 | Synchronous exception source |
| sync_kind_i | input | 4 | Synchronous exception kind (R5 encoding) |
| xlat_res_i | input | 2 | Translation lookup result (R8 encoding) |
| is_store_i | input | 1 | 1 for a store access, 0 for a load |
| fault_addr_i | input | 32 | Faulting virtual address |
| cop_num_i | input | 2 | Coprocessor number for coprocessor-unusable |
| pc_i | input | 32 | PC of the excepting instruction |
| in_delay_i | input | 1 | Instruction sits in a branch delay slot |
| exl_i | input | 1 | Current exception-level bit |
| bev_i | input | 1 | Current boot-vector bit |
| iv_i | input | 1 | Special interrupt vector enable |
| ebase_i | input | 32 | Exception-base register |
| context_i | input | 32 | Current context register |
| asid_i | input | 8 | Current address-space identifier |
| taken_o | output | 1 | One-cycle pulse: an exception was entered |
| new_pc_o | output | 32 | Vector address to fetch from |
| epc_we_o | output | 1 | Write enable for EPC and BD |
| epc_o | output | 32 | Return address for general exceptions |
| bd_o | output | 1 | Delay-slot flag for the cause register |
| errepc_we_o | output | 1 | Write enable for error return address |
| errepc_o | output | 32 | Return address for reset/NMI |
| cause_we_o | output | 1 | Write enable for the cause code |
| exc_code_o | output | 5 | Cause code |
| ce_we_o | output | 1 | Write enable for the coprocessor field |
| ce_o | output | 2 | Faulting coprocessor number |
| exl_set_o | output | 1 | Request to set the exception-level bit |
| erl_set_o | output | 1 | Request to set the error-level bit |
| bev_set_o | output | 1 | Request to set the boot-vector bit |
| sr_set_o | output | 1 | Request to set the soft-reset flag |
| nmi_set_o | output | 1 | Request to set the NMI flag |
| xlat_we_o | output | 1 | Write enable for the fault-capture registers |
| badvaddr_o | output | 32 | Captured faulting address |
| context_o | output | 32 | Merged context value |
| entryhi_o | output | 32 | Merged entry-high value |

## Verification
The bench goes after the cases where two rules meet.

- **Refill fault with `exl_i` set:** it must fall back to offset 0x180. A design that ignored EXL here would jump into the refill handler while already inside a handler.
- **Nested exception with EXL set:** EPC and BD must be preserved. A design that wrote them anyway would lose the original return address.
- **Delay-slot rewind:** a wrong rewind would return past the branch.
- **Priority:** all four sources are raised together and in pairs. A wrong order would shadow an NMI.
- **Ignored cycles:** reserved kinds and unqualified flags are checked for holding every data output. A leaky hold would corrupt EPC or BadVAddr without any strobe.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN       = 32;
  localparam int ASID_W     = 8;
  localparam int CODE_W     = 5;
  localparam int KIND_W     = 4;
  localparam int RES_W      = 2;
  localparam int CE_W       = 2;
  localparam int EBASE_LSB  = 10;
  localparam int PAIR_LSB   = 13;
  localparam int CTX_SHIFT  = 9;

  localparam logic [XLEN-1:0] BOOT_VEC   = 32'hBFC0_0000;
  localparam logic [XLEN-1:0] BEV_BASE   = 32'hBFC0_0200;
  localparam logic [XLEN-1:0] OFF_GEN    = 32'h0000_0180;
  localparam logic [XLEN-1:0] OFF_IRQV   = 32'h0000_0200;
  localparam logic [XLEN-1:0] OFF_REFILL = 32'h0000_0000;
  localparam logic [XLEN-1:0] CTX_FIELD  = 32'h007F_FFF0;
  localparam logic [XLEN-1:0] CTX_KEEP   = ~32'h007F_FFFF;
  localparam logic [XLEN-1:0] EBASE_KEEP = ~((XLEN'(1) << EBASE_LSB) - XLEN'(1));
  localparam logic [XLEN-1:0] INSN_BYTES = 32'd4;

  typedef enum logic [KIND_W-1:0] {
    K_XLAT = 4'd0, K_IBUS = 4'd1, K_DBUS = 4'd2, K_SYSCALL = 4'd3,
    K_BREAK = 4'd4, K_RSVD = 4'd5, K_COPUN = 4'd6, K_OVF = 4'd7,
    K_TRAP = 4'd8, K_FPE = 4'd9
  } sync_kind_e;
  localparam logic [KIND_W-1:0] KIND_LAST = 4'd9;

  typedef enum logic [RES_W-1:0] {
    XR_BADADDR = 2'd0, XR_NOMATCH = 2'd1, XR_INVALID = 2'd2, XR_DIRTY = 2'd3
  } xlat_res_e;

  localparam logic [CODE_W-1:0] CODE_IRQ = 5'd0;

  function automatic logic [CODE_W-1:0] sync_code(logic [KIND_W-1:0] kind,
                                                   logic [RES_W-1:0] res,
                                                   logic store);
    case (sync_kind_e'(kind))
      K_XLAT: begin
        case (xlat_res_e'(res))
          XR_BADADDR: return store ? 5'd5 : 5'd4;
          XR_DIRTY:   return 5'd1;
          default:    return store ? 5'd3 : 5'd2;
        endcase
      end
      K_IBUS:    return 5'd6;
      K_DBUS:    return 5'd7;
      K_SYSCALL: return 5'd8;
      K_BREAK:   return 5'd9;
      K_RSVD:    return 5'd10;
      K_COPUN:   return 5'd11;
      K_OVF:     return 5'd12;
      K_TRAP:    return 5'd13;
      K_FPE:     return 5'd15;
      default:   return 5'd0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] vec_base(logic bev, logic [XLEN-1:0] ebase);
    return bev ? BEV_BASE : (ebase & EBASE_KEEP);
  endfunction

  function automatic logic [XLEN-1:0] vec_offset(logic is_irq, logic iv,
                                                 logic refill, logic exl);
    if (is_irq) return iv ? OFF_IRQV : OFF_GEN;
    return (refill && !exl) ? OFF_REFILL : OFF_GEN;
  endfunction

  function automatic logic [XLEN-1:0] resume_pc(logic [XLEN-1:0] pc, logic in_delay);
    return in_delay ? (pc - INSN_BYTES) : pc;
  endfunction

  function automatic logic [XLEN-1:0] ctx_merge(logic [XLEN-1:0] ctx,
                                                logic [XLEN-1:0] addr);
    return (ctx & CTX_KEEP) | ((addr >> CTX_SHIFT) & CTX_FIELD);
  endfunction

  function automatic logic [XLEN-1:0] entryhi_merge(logic [ASID_W-1:0] asid,
                                                    logic [XLEN-1:0] addr);
    return {addr[XLEN-1:PAIR_LSB], {(PAIR_LSB-ASID_W){1'b0}}, asid};
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              srst_i,
  input  logic              nmi_i,
  input  logic              irq_i,
  input  logic              sync_i,
  input  logic [KIND_W-1:0] kind_i,
  output logic              g_srst_o,
  output logic              g_nmi_o,
  output logic              g_irq_o,
  output logic              g_sync_o
);
  logic       kind_ok;
  logic [3:0] grant;

  assign kind_ok  = (kind_i <= KIND_LAST);
  assign g_srst_o = valid_i && srst_i;
  assign g_nmi_o  = valid_i && nmi_i && !srst_i;
  assign g_irq_o  = valid_i && irq_i && !srst_i && !nmi_i;
  assign g_sync_o = valid_i && sync_i && kind_ok && !srst_i && !nmi_i && !irq_i;
  assign grant    = {g_sync_o, g_irq_o, g_nmi_o, g_srst_o};

  // R2: at most one source wins
  a_r2_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  // R2: a raised soft reset always wins over everything else
  a_r2_srst_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && srst_i) |-> (grant == 4'b0001));
  // R11: reserved kinds alone never produce a grant
  a_r11_reserved_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !kind_ok && !srst_i && !nmi_i && !irq_i) |-> (grant == 4'b0000));
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
(
  input  logic            irq_i,
  input  logic            iv_i,
  input  logic            bev_i,
  input  logic            exl_i,
  input  logic            refill_i,
  input  logic [XLEN-1:0] ebase_i,
  output logic [XLEN-1:0] vec_o
);
  logic [XLEN-1:0] base, offs;

  assign base  = vec_base(bev_i, ebase_i);
  assign offs  = vec_offset(irq_i, iv_i, refill_i, exl_i);
  assign vec_o = base + offs;
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_srst_i,
  input  logic              req_nmi_i,
  input  logic              req_irq_i,
  input  logic              req_sync_i,
  input  logic [KIND_W-1:0] sync_kind_i,
  input  logic [RES_W-1:0]  xlat_res_i,
  input  logic              is_store_i,
  input  logic [XLEN-1:0]   fault_addr_i,
  input  logic [CE_W-1:0]   cop_num_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              in_delay_i,
  input  logic              exl_i,
  input  logic              bev_i,
  input  logic              iv_i,
  input  logic [XLEN-1:0]   ebase_i,
  input  logic [XLEN-1:0]   context_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   new_pc_o,
  output logic              epc_we_o,
  output logic [XLEN-1:0]   epc_o,
  output logic              bd_o,
  output logic              errepc_we_o,
  output logic [XLEN-1:0]   errepc_o,
  output logic              cause_we_o,
  output logic [CODE_W-1:0] exc_code_o,
  output logic              ce_we_o,
  output logic [CE_W-1:0]   ce_o,
  output logic              exl_set_o,
  output logic              erl_set_o,
  output logic              bev_set_o,
  output logic              sr_set_o,
  output logic              nmi_set_o,
  output logic              xlat_we_o,
  output logic [XLEN-1:0]   badvaddr_o,
  output logic [XLEN-1:0]   context_o,
  output logic [XLEN-1:0]   entryhi_o
);
  logic g_srst, g_nmi, g_irq, g_sync;
  logic take_boot, take_gen, is_xlat, is_copun, refill_hit;
  logic [CODE_W-1:0] gen_code;
  logic [XLEN-1:0]   gen_vec, ret_pc;

  exc_arbiter u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(req_valid_i),
    .srst_i(req_srst_i), .nmi_i(req_nmi_i), .irq_i(req_irq_i),
    .sync_i(req_sync_i), .kind_i(sync_kind_i),
    .g_srst_o(g_srst), .g_nmi_o(g_nmi), .g_irq_o(g_irq), .g_sync_o(g_sync)
  );

  // named internal events, used by the assertions below
  assign take_boot  = g_srst || g_nmi;
  assign take_gen   = g_irq || g_sync;
  assign is_xlat    = g_sync && (sync_kind_e'(sync_kind_i) == K_XLAT);
  assign is_copun   = g_sync && (sync_kind_e'(sync_kind_i) == K_COPUN);
  assign refill_hit = is_xlat && (xlat_res_e'(xlat_res_i) == XR_NOMATCH);
  assign gen_code   = g_irq ? CODE_IRQ : sync_code(sync_kind_i, xlat_res_i, is_store_i);
  assign ret_pc     = resume_pc(pc_i, in_delay_i);

  exc_vector u_vec (
    .irq_i(g_irq), .iv_i(iv_i), .bev_i(bev_i), .exl_i(exl_i),
    .refill_i(refill_hit), .ebase_i(ebase_i), .vec_o(gen_vec)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      taken_o <= 1'b0;  new_pc_o <= '0;  epc_we_o <= 1'b0;  epc_o <= '0;  bd_o <= 1'b0;
      errepc_we_o <= 1'b0;  errepc_o <= '0;  cause_we_o <= 1'b0;  exc_code_o <= '0;
      ce_we_o <= 1'b0;  ce_o <= '0;  exl_set_o <= 1'b0;  erl_set_o <= 1'b0;
      bev_set_o <= 1'b0;  sr_set_o <= 1'b0;  nmi_set_o <= 1'b0;  xlat_we_o <= 1'b0;
      badvaddr_o <= '0;  context_o <= '0;  entryhi_o <= '0;
    end else begin
      taken_o <= take_boot || take_gen;
      epc_we_o <= 1'b0;  errepc_we_o <= 1'b0;  cause_we_o <= 1'b0;  ce_we_o <= 1'b0;
      exl_set_o <= 1'b0;  erl_set_o <= 1'b0;  bev_set_o <= 1'b0;
      sr_set_o <= 1'b0;  nmi_set_o <= 1'b0;  xlat_we_o <= 1'b0;
      if (take_boot) begin
        new_pc_o    <= BOOT_VEC;
        errepc_we_o <= 1'b1;
        errepc_o    <= ret_pc;
        erl_set_o   <= 1'b1;
        bev_set_o   <= 1'b1;
        sr_set_o    <= g_srst;
        nmi_set_o   <= g_nmi;
      end else if (take_gen) begin
        new_pc_o   <= gen_vec;
        cause_we_o <= 1'b1;
        exc_code_o <= gen_code;
        if (!exl_i) begin
          epc_we_o  <= 1'b1;
          epc_o     <= ret_pc;
          bd_o      <= in_delay_i;
          exl_set_o <= 1'b1;
        end
        if (is_copun) begin
          ce_we_o <= 1'b1;
          ce_o    <= cop_num_i;
        end
        if (is_xlat) begin
          xlat_we_o  <= 1'b1;
          badvaddr_o <= fault_addr_i;
          context_o  <= ctx_merge(context_i, fault_addr_i);
          entryhi_o  <= entryhi_merge(asid_i, fault_addr_i);
        end
      end
    end
  end

  // R6: EPC is written only for an exception raised with EXL clear
  a_r6_epc_only_exl_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_we_o |-> !$past(exl_i));
  // R6: a delay-slot fault rewinds the saved PC to the branch
  a_r6_delay_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epc_we_o && bd_o) |-> (epc_o == $past(pc_i) - 32'd4));
  // R6: with EXL set the saved return address holds
  a_r6_epc_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && !epc_we_o) |-> $stable(epc_o));
  // R7: reset/NMI entry goes to the boot vector and never writes the cause code
  a_r7_boot_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erl_set_o |-> (new_pc_o == BOOT_VEC && bev_set_o && errepc_we_o && !cause_we_o && !epc_we_o));
  // R3: boot-vector base is used for general exceptions while BEV is set
  a_r3_bev_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_we_o && $past(bev_i)) |-> (new_pc_o[31:12] == 20'hBFC00));
  // R9: entry-high keeps the ASID and the address bits of the faulting page pair
  a_r9_entryhi_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xlat_we_o |-> (entryhi_o[31:13] == badvaddr_o[31:13] && entryhi_o[7:0] == $past(asid_i)));
  // R12: every entry is the result of a request on the previous edge
  a_r12_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> $past(req_valid_i));
  // R11: without a valid request nothing is taken on the next edge
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !taken_o);
endmodule

// File: tb/exc_entry_unit_test.sv
`timescale 1ns/1ps
module exc_entry_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid, req_srst, req_nmi, req_irq, req_sync, is_store, in_delay, exl, bev, iv;
  logic [3:0]  sync_kind;
  logic [1:0]  xlat_res, cop_num;
  logic [7:0]  asid;
  logic [31:0] fault_addr, pc, ebase, ctx;

  logic taken, epc_we, bd, errepc_we, cause_we, ce_we, exl_set, erl_set, bev_set, sr_set, nmi_set, xlat_we;
  logic [31:0] new_pc, epc, errepc, badvaddr, context_q, entryhi;
  logic [4:0]  code;
  logic [1:0]  ce;

  exc_entry_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_srst_i(req_srst),
    .req_nmi_i(req_nmi), .req_irq_i(req_irq), .req_sync_i(req_sync),
    .sync_kind_i(sync_kind), .xlat_res_i(xlat_res), .is_store_i(is_store),
    .fault_addr_i(fault_addr), .cop_num_i(cop_num), .pc_i(pc), .in_delay_i(in_delay),
    .exl_i(exl), .bev_i(bev), .iv_i(iv), .ebase_i(ebase), .context_i(ctx), .asid_i(asid),
    .taken_o(taken), .new_pc_o(new_pc), .epc_we_o(epc_we), .epc_o(epc), .bd_o(bd),
    .errepc_we_o(errepc_we), .errepc_o(errepc), .cause_we_o(cause_we), .exc_code_o(code),
    .ce_we_o(ce_we), .ce_o(ce), .exl_set_o(exl_set), .erl_set_o(erl_set),
    .bev_set_o(bev_set), .sr_set_o(sr_set), .nmi_set_o(nmi_set), .xlat_we_o(xlat_we),
    .badvaddr_o(badvaddr), .context_o(context_q), .entryhi_o(entryhi)
  );

  // ---------------- reference model ----------------
  int n_checks = 0, n_fails = 0;
  string phase = "R1_reset", e_phase = "R1_reset";
  bit e_taken, e_epc_we, e_bd, e_errepc_we, e_cause_we, e_ce_we, e_exl_set, e_erl_set;
  bit e_bev_set, e_sr_set, e_nmi_set, e_xlat_we;
  logic [31:0] e_pc, e_epc, e_errepc, e_bad, e_ctx, e_ehi;
  int e_code, e_ce;
  int who, vb, vo;
  bit refill;

  function automatic int model_code(int kind, int res, bit st);
    if (kind == 0) begin
      if (res == 3) return 1;
      if (res == 0) return st ? 5 : 4;
      return st ? 3 : 2;
    end
    if (kind == 9) return 15;
    return kind + 5;
  endfunction

  always @(posedge clk) begin
    e_phase = phase;
    {e_taken, e_epc_we, e_errepc_we, e_cause_we, e_ce_we, e_exl_set} = '0;
    {e_erl_set, e_bev_set, e_sr_set, e_nmi_set, e_xlat_we} = '0;
    if (!rst_n) begin
      e_pc = 0; e_epc = 0; e_bd = 0; e_errepc = 0; e_code = 0; e_ce = 0;
      e_bad = 0; e_ctx = 0; e_ehi = 0;
    end else if (req_valid) begin
      who = 0;
      if (req_srst) who = 1;
      else if (req_nmi) who = 2;
      else if (req_irq) who = 3;
      else if (req_sync && sync_kind < 10) who = 4;
      if (who == 1 || who == 2) begin
        e_taken = 1; e_pc = 32'hBFC00000; e_errepc_we = 1;
        e_errepc = in_delay ? pc - 4 : pc;
        e_erl_set = 1; e_bev_set = 1; e_sr_set = (who == 1); e_nmi_set = (who == 2);
      end else if (who >= 3) begin
        e_taken = 1; e_cause_we = 1;
        e_code = (who == 3) ? 0 : model_code(int'(sync_kind), int'(xlat_res), is_store);
        refill = (who == 4) && sync_kind == 0 && xlat_res == 1;
        vb = bev ? 32'hBFC00200 : int'({ebase[31:10], 10'd0});
        if (who == 3) vo = iv ? 'h200 : 'h180;
        else vo = (refill && !exl) ? 0 : 'h180;
        e_pc = vb + vo;
        if (!exl) begin
          e_epc_we = 1; e_exl_set = 1; e_bd = in_delay;
          e_epc = in_delay ? pc - 4 : pc;
        end
        if (who == 4 && sync_kind == 6) begin e_ce_we = 1; e_ce = int'(cop_num); end
        if (who == 4 && sync_kind == 0) begin
          e_xlat_we = 1; e_bad = fault_addr;
          e_ctx = {ctx[31:23], 23'd0} + {9'd0, fault_addr[31:13], 4'd0};
          e_ehi = {fault_addr[31:13], 5'd0, asid};
        end
      end
    end
  end

  task automatic cmp(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s (case %s): actual %h expected %h", tag, what, e_phase, got, exp);
    end
  endtask

  bit running = 0;
  always @(negedge clk) if (running) begin
    cmp("R12", "taken", 32'(taken), 32'(e_taken));
    cmp("R3", "new_pc", new_pc, e_pc);
    cmp("R6", "epc_we", 32'(epc_we), 32'(e_epc_we));
    cmp("R6", "epc", epc, e_epc);
    cmp("R6", "bd", 32'(bd), 32'(e_bd));
    cmp("R6", "exl_set", 32'(exl_set), 32'(e_exl_set));
    cmp("R7", "errepc_we", 32'(errepc_we), 32'(e_errepc_we));
    cmp("R7", "errepc", errepc, e_errepc);
    cmp("R7", "erl/bev/sr/nmi", {28'd0, erl_set, bev_set, sr_set, nmi_set},
        {28'd0, e_erl_set, e_bev_set, e_sr_set, e_nmi_set});
    cmp("R5", "cause_we", 32'(cause_we), 32'(e_cause_we));
    cmp("R5", "code", 32'(code), 32'(e_code));
    cmp("R10", "ce", {29'd0, ce_we, ce}, {29'd0, e_ce_we, 2'(e_ce)});
    cmp("R9", "xlat_we", 32'(xlat_we), 32'(e_xlat_we));
    cmp("R9", "badvaddr", badvaddr, e_bad);
    cmp("R9", "context", context_q, e_ctx);
    cmp("R9", "entryhi", entryhi, e_ehi);
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    req_valid = 0; req_srst = 0; req_nmi = 0; req_irq = 0; req_sync = 0;
  endtask

  task automatic base(input bit d, input bit x, input bit b);
    in_delay = d; exl = x; bev = b;
  endtask

  task automatic fire_sync(input string p, input int kind, input int res, input bit st);
    @(negedge clk); phase = p; idle();
    req_valid = 1; req_sync = 1; sync_kind = 4'(kind); xlat_res = 2'(res); is_store = st;
    @(negedge clk); phase = {p, "_hold"}; idle();
  endtask

  task automatic fire_mix(input string p, input bit s, input bit n, input bit i, input bit y, input bit v);
    @(negedge clk); phase = p; idle();
    req_valid = v; req_srst = s; req_nmi = n; req_irq = i; req_sync = y;
    @(negedge clk); phase = {p, "_hold"}; idle();
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    idle(); sync_kind = 0; xlat_res = 0; is_store = 0; cop_num = 2'd2;
    pc = 32'h8000_1000; fault_addr = 32'h1234_5678; ebase = 32'h8000_1234;
    ctx = 32'hA5A5_A5A5; asid = 8'h3C; iv = 0; base(0, 0, 1);
    running = 1;
    repeat (3) @(negedge clk);          // R1: outputs zero during reset
    rst_n = 1;
    // R5, R3: syscall with BEV set
    fire_sync("R5_syscall_bev", 3, 0, 0);
    // R6: break in delay slot, BEV clear -> ebase vector, EPC rewound
    base(1, 0, 0); fire_sync("R6_break_delay", 4, 0, 0);
    // R4, R8, R9: no-match load with EXL clear -> refill offset
    base(0, 0, 0); fire_sync("R8_nomatch_load_refill", 0, 1, 0);
    // R4, R6: no-match store with EXL set -> general offset, EPC held
    base(1, 1, 0); fault_addr = 32'hC000_2468; fire_sync("R4_nomatch_store_exl", 0, 1, 1);
    base(0, 0, 1); fire_sync("R8_invalid_load", 0, 2, 0);
    fire_sync("R8_dirty", 0, 3, 1);
    fire_sync("R8_badaddr_store", 0, 0, 1);
    fire_sync("R8_badaddr_load", 0, 0, 0);
    // R10: coprocessor unusable
    cop_num = 2'd3; fire_sync("R10_copun", 6, 0, 0);
    fire_sync("R5_fpe", 9, 0, 0);
    // R4: interrupt with and without IV
    iv = 1; base(0, 0, 0); fire_mix("R4_irq_iv", 0, 0, 1, 0, 1);
    iv = 0; fire_mix("R4_irq_plain", 0, 0, 1, 0, 1);
    // R7: NMI in a delay slot, soft reset
    base(1, 0, 0); fire_mix("R7_nmi_delay", 0, 1, 0, 0, 1);
    base(0, 0, 0); fire_mix("R7_srst", 1, 0, 0, 0, 1);
    // R2: priority
    sync_kind = 3; fire_mix("R2_all_four", 1, 1, 1, 1, 1);
    fire_mix("R2_nmi_irq", 0, 1, 1, 1, 1);
    fire_mix("R2_irq_sync", 0, 0, 1, 1, 1);
    // R11: ignored cycles
    fire_mix("R11_no_valid", 1, 1, 1, 1, 0);
    fire_sync("R11_reserved_kind", 12, 0, 0);
    fire_sync("R11_reserved_kind15", 15, 1, 1);
    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      @(negedge clk); phase = "R12_random";
      req_valid = ($urandom_range(0, 3) != 0);
      req_srst = ($urandom_range(0, 15) == 0); req_nmi = ($urandom_range(0, 11) == 0);
      req_irq = ($urandom_range(0, 5) == 0); req_sync = ($urandom_range(0, 1) == 1);
      sync_kind = 4'($urandom_range(0, 15)); xlat_res = 2'($urandom_range(0, 3));
      is_store = 1'($urandom_range(0, 1)); cop_num = 2'($urandom_range(0, 3));
      in_delay = 1'($urandom_range(0, 1)); exl = 1'($urandom_range(0, 1));
      bev = 1'($urandom_range(0, 1)); iv = 1'($urandom_range(0, 1));
      pc = $urandom; fault_addr = $urandom; ebase = $urandom; ctx = $urandom;
      asid = 8'($urandom_range(0, 255));
    end
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule